// File: doc/BRIEF.md
# Prescaled Sequencer Delay Timer

This block delays one step of a conversion sequencer by a programmable time. The host stores a 16-bit delay value N in a preset register. It writes that register one byte lane at a time and reads it back in full. When the sequencer reaches its wait state on an instruction that asks for a delay, it raises a one-cycle `wait_enter` strobe together with `timer_en`. The timer then copies the preset into its counter. It raises `hold` for exactly 32·N + 2 clock cycles, and `done` marks the final cycle of that window.

The delay comes from a 5-bit prescaler chained into a 16-bit down-counter. After the counter runs out, a fixed two-cycle tail follows, so a zero preset still gives a two-cycle hold. The counter is reloaded from the preset each time a delay starts. A preset written while a delay is running therefore only affects later delays. Dropping `run_en` cancels a delay in progress, and so does reset.

Top module: `seq_delay_timer`

## Requirements
- R1: After reset the preset reads 0. `preset_be[0]` writes bits 7:0 and `preset_be[1]` writes bits 15:8 from `preset_wdata`. A lane whose strobe is low keeps its value. `preset_q` shows the full 16-bit preset one cycle after the write edge.
- R2: A delay starts on a clock edge where `hold` is low and `wait_enter`, `timer_en` and `run_en` are all high. `hold` is high in the following cycle.
- R3: Once started, `hold` stays high for exactly 32·N + 2 consecutive cycles, where N is the preset value at the start edge.
- R4: With N = 0, `hold` lasts exactly 2 cycles.
- R5: A `wait_enter` strobe with `timer_en` low does not raise `hold`.
- R6: Each delay loads the preset value current at its own start edge. Back-to-back delays with different presets give different lengths.
- R7: A preset write during a running delay does not change that delay's length. The new value is visible on `preset_q` at once and is used by the next delay.
- R8: If `run_en` is low on a clock edge, `hold` is low in the following cycle. A delay cancelled this way never raises `done`.
- R9: Asserting `rst_n` low cancels a running delay, drops `hold` and clears the preset to 0.
- R10: `done` is high for exactly one cycle per completed delay, and that cycle is the last cycle of `hold`.
- R11: A `wait_enter` strobe while `hold` is high is ignored. The running delay neither restarts nor changes length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Sequencer run enable; low cancels a delay |
| preset_be | input | 2 | Byte-lane write strobes for the preset |
| preset_wdata | input | 16 | Preset write data |
| preset_q | output | 16 | Current preset value |
| wait_enter | input | 1 | Sequencer entered its wait state (one-cycle strobe) |
| timer_en | input | 1 | Timer-enable bit of the current instruction |
| hold | output | 1 | Keeps the sequencer in its wait state |
| done | output | 1 | High in the last cycle of a completed delay |

## Verification
A counter that is off by one, or a prescaler that wraps at the wrong value, changes the hold length. A prescaler error scales with N, so the bench measures hold windows for several presets. These include zero, small values and one that uses the high byte. An error shows up as a wrong count at the latest when `hold` falls. A state machine that fails to return to idle shows up within one cycle as `hold` staying high after a cancel, or as a second or missing `done`. A counter that reloads at the wrong moment shows up when a mid-delay preset write or a repeated `wait_enter` changes the measured length.

// File: rtl/tdly_pkg.sv
package tdly_pkg;
   typedef enum logic [1:0] {
      TD_IDLE  = 2'd0,
      TD_COUNT = 2'd1,
      TD_TAIL  = 2'd2
   } tdly_state_e;
endpackage

// File: rtl/tdly_preset_reg.sv
module tdly_preset_reg #(
   parameter int CNT_W = 16,
   localparam int LANES = CNT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] wr_be,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] q
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[g*8 +: 8] <= '0;
         else if (wr_be[g])
            q[g*8 +: 8] <= wr_data[g*8 +: 8];
      end
   end
endmodule

// File: rtl/tdly_prescaler.sv
module tdly_prescaler #(
   parameter int PRE_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic tick
);
   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (load)
         pre_q <= '1;
      else if (run)
         pre_q <= pre_q - 1'b1;
   end

   assign tick = run && (pre_q == '0);
endmodule

// File: rtl/tdly_downcnt.sv
module tdly_downcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             at_one
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign at_one = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer
   import tdly_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 5,
   parameter int TAIL_CYC = 2,
   localparam int LANES   = CNT_W / 8,
   localparam int TAIL_W  = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [LANES-1:0] preset_be,
   input  logic [CNT_W-1:0] preset_wdata,
   output logic [CNT_W-1:0] preset_q,
   input  logic             wait_enter,
   input  logic             timer_en,
   output logic             hold,
   output logic             done
);
   if (CNT_W % 8 != 0 || CNT_W < 8) begin : g_bad_cnt_w
      $error("CNT_W must be a positive multiple of 8");
   end
   if (PRE_W < 0 || PRE_W > 16) begin : g_bad_pre_w
      $error("PRE_W out of range");
   end
   if (TAIL_CYC < 1) begin : g_bad_tail
      $error("TAIL_CYC must be at least 1");
   end

   tdly_state_e      state_q, state_d;
   logic [TAIL_W-1:0] tail_q;
   logic             start, counting, pre_tick, cnt_one, tail_last, preset_zero;

   tdly_preset_reg #(.CNT_W(CNT_W)) u_preset (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_be   (preset_be),
      .wr_data (preset_wdata),
      .q       (preset_q)
   );

   assign counting    = (state_q == TD_COUNT);
   assign start       = (state_q == TD_IDLE) && wait_enter && timer_en && run_en;
   assign preset_zero = (preset_q == '0);

   if (PRE_W > 0) begin : g_prescale
      tdly_prescaler #(.PRE_W(PRE_W)) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (start),
         .run   (counting),
         .tick  (pre_tick)
      );
   end else begin : g_no_prescale
      assign pre_tick = counting;
   end

   tdly_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (preset_q),
      .dec      (pre_tick),
      .at_one   (cnt_one)
   );

   assign tail_last = (tail_q == TAIL_W'(TAIL_CYC - 1));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TD_IDLE:  if (start) state_d = preset_zero ? TD_TAIL : TD_COUNT;
         TD_COUNT: if (pre_tick && cnt_one) state_d = TD_TAIL;
         TD_TAIL:  if (tail_last) state_d = TD_IDLE;
         default:  state_d = TD_IDLE;
      endcase
      if (!run_en) state_d = TD_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TD_IDLE;
         tail_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == TD_TAIL && !tail_last)
            tail_q <= tail_q + 1'b1;
         else
            tail_q <= '0;
      end
   end

   assign hold = (state_q != TD_IDLE);
   assign done = (state_q == TD_TAIL) && tail_last && run_en;
endmodule

// File: rtl/tdly_timer_chk.sv
module tdly_timer_chk #(
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 5,
   parameter int TAIL_CYC = 2,
   localparam int LANES   = CNT_W / 8,
   localparam int LEN_W   = CNT_W + PRE_W + 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic [LANES-1:0] preset_be,
   input logic [CNT_W-1:0] preset_q,
   input logic             wait_enter,
   input logic             timer_en,
   input logic             hold,
   input logic             done
);
   logic             accept;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] exp_len_q;

   assign accept = !hold && wait_enter && timer_en && run_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= LEN_W'(1);
         exp_len_q <= LEN_W'(TAIL_CYC);
      end else begin
         len_q <= hold ? len_q + 1'b1 : LEN_W'(1);
         if (accept)
            exp_len_q <= (LEN_W'(preset_q) << PRE_W) + LEN_W'(TAIL_CYC);
      end
   end

   // R2
   a_r2_start_raises_hold: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> hold);
   // R5
   a_r5_disabled_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && wait_enter && !timer_en) |=> !hold);
   // R8
   a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !hold);
   // R3
   a_r3_window_length: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len_q == exp_len_q));
   // R10
   a_r10_done_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> hold);
   a_r10_done_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !hold);
   // R11
   a_r11_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && run_en && !done) |=> hold);
   // R1
   a_r1_preset_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_be == '0) |=> $stable(preset_q));
endmodule

bind seq_delay_timer tdly_timer_chk #(
   .CNT_W    (CNT_W),
   .PRE_W    (PRE_W),
   .TAIL_CYC (TAIL_CYC)
) u_tdly_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_en     (run_en),
   .preset_be  (preset_be),
   .preset_q   (preset_q),
   .wait_enter (wait_enter),
   .timer_en   (timer_en),
   .hold       (hold),
   .done       (done)
);

// File: tb/test_seq_delay_timer.sv
`timescale 1ns/1ps
module test_seq_delay_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [1:0]  preset_be = 2'b00;
   logic [15:0] preset_wdata = 16'h0000;
   logic [15:0] preset_q;
   logic        wait_enter = 1'b0;
   logic        timer_en = 1'b0;
   logic        hold;
   logic        done;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   seq_delay_timer i_seq_delay_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .preset_be    (preset_be),
      .preset_wdata (preset_wdata),
      .preset_q     (preset_q),
      .wait_enter   (wait_enter),
      .timer_en     (timer_en),
      .hold         (hold),
      .done         (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_preset(input logic [1:0] be, input logic [15:0] val);
      @(negedge clk);
      preset_be    = be;
      preset_wdata = val;
      @(negedge clk);
      preset_be    = 2'b00;
   endtask

   task automatic start_wait();
      @(negedge clk);
      wait_enter = 1'b1;
      timer_en   = 1'b1;
      @(negedge clk);
      wait_enter = 1'b0;
      timer_en   = 1'b0;
   endtask

   // act_kind: 0 none, 1 rewrite preset to act_val, 2 re-strobe wait_enter
   task automatic measure(input int act_at, input int act_kind, input logic [15:0] act_val,
                          output int len, output int dones, output int done_at);
      len = 0; dones = 0; done_at = -1;
      while (hold && len < 100000) begin
         len++;
         if (done) begin dones++; done_at = len; end
         if (len == act_at && act_kind == 1) begin preset_be = 2'b11; preset_wdata = act_val; end
         if (len == act_at && act_kind == 2) begin wait_enter = 1'b1; timer_en = 1'b1; end
         if (len == act_at + 1) begin preset_be = 2'b00; wait_enter = 1'b0; timer_en = 1'b0; end
         @(negedge clk);
      end
      preset_be = 2'b00; wait_enter = 1'b0; timer_en = 1'b0;
   endtask

   task automatic t_delay(input logic [15:0] n, input string req);
      int len, dn, dat;
      write_preset(2'b11, n);
      start_wait();
      check(hold == 1'b1, "R2 hold after start", int'(hold), 1);
      measure(0, 0, 16'h0, len, dn, dat);
      check(len == 32 * int'(n) + 2, req, len, 32 * int'(n) + 2);
      check(dn == 1 && dat == len, "R10 single done on last hold cycle", dat, len);
   endtask

   task automatic t_reset_state();
      check(hold == 1'b0 && done == 1'b0, "R9 outputs idle after reset", int'({hold, done}), 0);
      check(preset_q == 16'h0, "R1 preset resets to 0", int'(preset_q), 0);
   endtask

   task automatic t_preset_bytes();
      write_preset(2'b01, 16'hAB34);
      check(preset_q == 16'h0034, "R1 low lane only", int'(preset_q), 16'h0034);
      write_preset(2'b10, 16'h12FF);
      check(preset_q == 16'h1234, "R1 high lane only", int'(preset_q), 16'h1234);
   endtask

   task automatic t_disabled();
      int seen = 0;
      write_preset(2'b11, 16'd3);
      @(negedge clk);
      wait_enter = 1'b1; timer_en = 1'b0;
      @(negedge clk);
      wait_enter = 1'b0;
      for (int i = 0; i < 5; i++) begin
         if (hold) seen++;
         @(negedge clk);
      end
      check(seen == 0, "R5 no hold when timer_en low", seen, 0);
   endtask

   task automatic t_reload();
      int len, dn, dat;
      write_preset(2'b11, 16'd5);
      start_wait();
      measure(0, 0, 16'h0, len, dn, dat);
      check(len == 162, "R6 first delay uses preset 5", len, 162);
      write_preset(2'b11, 16'd2);
      start_wait();
      measure(0, 0, 16'h0, len, dn, dat);
      check(len == 66, "R6 reload uses preset 2", len, 66);
   endtask

   task automatic t_midwrite();
      int len, dn, dat;
      write_preset(2'b11, 16'd4);
      start_wait();
      measure(10, 1, 16'd9, len, dn, dat);
      check(len == 130, "R7 mid-delay write ignored by running delay", len, 130);
      check(preset_q == 16'd9, "R7 new preset visible", int'(preset_q), 9);
      start_wait();
      measure(0, 0, 16'h0, len, dn, dat);
      check(len == 290, "R7 next delay uses new preset", len, 290);
   endtask

   task automatic t_reenter();
      int len, dn, dat;
      write_preset(2'b11, 16'd3);
      start_wait();
      measure(40, 2, 16'h0, len, dn, dat);
      check(len == 98, "R11 wait_enter during hold ignored", len, 98);
      check(dn == 1, "R11 one done", dn, 1);
   endtask

   task automatic t_abort();
      int dn = 0;
      int len, d2, dat;
      write_preset(2'b11, 16'd10);
      start_wait();
      for (int i = 0; i < 50; i++) begin
         if (done) dn++;
         @(negedge clk);
      end
      run_en = 1'b0;
      @(negedge clk);
      check(hold == 1'b0, "R8 hold released after run_en low", int'(hold), 0);
      for (int i = 0; i < 5; i++) begin
         if (done || hold) dn++;
         @(negedge clk);
      end
      check(dn == 0, "R8 no done on cancelled delay", dn, 0);
      run_en = 1'b1;
      write_preset(2'b11, 16'd1);
      start_wait();
      measure(0, 0, 16'h0, len, d2, dat);
      check(len == 34, "R8 restart after cancel", len, 34);
   endtask

   task automatic t_reset_abort();
      write_preset(2'b11, 16'd6);
      start_wait();
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(hold == 1'b0, "R9 reset drops hold", int'(hold), 0);
      check(preset_q == 16'h0, "R9 reset clears preset", int'(preset_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      run_en = 1'b1;
      t_preset_bytes();
      t_delay(16'd0, "R4 zero preset holds 2 cycles");
      t_delay(16'd1, "R3 length for N=1");
      t_delay(16'd37, "R3 length for N=37");
      t_delay(16'h0101, "R3 length for N=257");
      t_disabled();
      t_reload();
      t_midwrite();
      t_reenter();
      t_abort();
      t_reset_abort();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule